// File: doc/BRIEF.md
# Dual-port GPIO register block with flash strobes and sensor clock

This block holds a small file of 32-bit words reached over a simple register bus. Two groups of three words form two general-purpose ports, called A and D. Each port has a driven value, an input view and an enable mask. The input view never returns a stored word. It returns the driven value masked by the enables, with one live input bit from an attached device OR-ed in.

Port A bits 6, 5 and 4 drive the address-latch, command-latch and chip-enable strobes of a NAND flash. Bit 7 of the port A input view shows the flash ready line. Port D bit 1 is the clock of a three-wire temperature sensor and bit 0 is the data sent to it. Bit 4 of the port D input view shows the bit the sensor sends back. Each write that toggles the sensor clock also produces a one-cycle pulse, which tells the sensor model whether the edge rose or fell.

The register bus accepts only full-word writes. Reads are combinational on the index. The other words of the file just store what is written to them.

Top module: `gpio_ports`

## Requirements
- R1: After reset, every stored word reads zero, the three flash strobes are low, and the sensor clock and sensor data are low.
- R2: A write with all four byte enables set to an index below 23 stores the word. A later read at that index returns it, unless the index is 0x01 or 0x11.
- R3: A read at index 0x01 returns (word 0x00 AND word 0x02) OR (flash ready << 7).
- R4: A read at index 0x11 returns (word 0x10 AND word 0x12) OR (sensor return bit << 4).
- R5: From the cycle after a full write to index 0x00, nand_ale follows bit 6 of the written word, nand_cle follows bit 5 and nand_ce follows bit 4.
- R6: sens_sck follows bit 1 of word 0x10 and sens_si follows bit 0 of word 0x10, from the cycle after the write.
- R7: A full write to index 0x10 whose bit 1 differs from the stored bit 1 raises sens_edge_up for one cycle if the new bit is 1, or sens_edge_dn for one cycle if it is 0. No pulse is produced when bit 1 is unchanged, and the two pulses are never high together.
- R8: A write with any byte enable clear changes no word, no strobe and no pulse.
- R9: Reads at indices 23 to 31 return zero. Writes there change no word, including the word at the index minus 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high |
| bus_be | input | 4 | Byte enables; a write needs all four set |
| bus_idx | input | 5 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx, combinational |
| nand_rdy | input | 1 | Flash ready line |
| sens_so | input | 1 | Bit returned by the sensor |
| nand_ale | output | 1 | Flash address-latch strobe |
| nand_cle | output | 1 | Flash command-latch strobe |
| nand_ce | output | 1 | Flash chip enable |
| sens_sck | output | 1 | Sensor clock level |
| sens_si | output | 1 | Data sent to the sensor |
| sens_edge_up | output | 1 | One-cycle pulse on a rising sensor clock write |
| sens_edge_dn | output | 1 | One-cycle pulse on a falling sensor clock write |

## Verification
The bench builds the block with the defaults: 32-bit words, 23 stored words and a 5-bit index. With these values the indices 23 to 31 exist on the bus but not in the file, so the bench can read them and write them. A write to index 25 is checked against word 9, which catches an address decode that drops the top index bit. Both port input views are read with each live input bit low and then high. The sensor clock is written up, written again at the same level, and written down, to cover each edge case.

// File: rtl/gpio_ports.sv
module gpio_ports #(
  parameter int DW     = 32,
  parameter int NWORDS = 23,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [3:0]       bus_be,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             nand_rdy,
  input  logic             sens_so,
  output logic             nand_ale,
  output logic             nand_cle,
  output logic             nand_ce,
  output logic             sens_sck,
  output logic             sens_si,
  output logic             sens_edge_up,
  output logic             sens_edge_dn
);
  localparam logic [IDX_W-1:0] A_OUT = IDX_W'(8'h00);
  localparam logic [IDX_W-1:0] A_IN  = IDX_W'(8'h01);
  localparam logic [IDX_W-1:0] A_OE  = IDX_W'(8'h02);
  localparam logic [IDX_W-1:0] D_OUT = IDX_W'(8'h10);
  localparam logic [IDX_W-1:0] D_IN  = IDX_W'(8'h11);
  localparam logic [IDX_W-1:0] D_OE  = IDX_W'(8'h12);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NWORDS - 1);
  localparam int RDY_BIT = 7;
  localparam int SO_BIT  = 4;
  localparam int ALE_BIT = 6;
  localparam int CLE_BIT = 5;
  localparam int CE_BIT  = 4;
  localparam int SCK_BIT = 1;
  localparam int SI_BIT  = 0;

  logic [DW-1:0] mem [NWORDS];

  logic wr_ok, wr_d;
  assign wr_ok = bus_en && bus_we && (&bus_be) && (bus_idx <= LAST);
  assign wr_d  = wr_ok && (bus_idx == D_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
      sens_edge_up <= 1'b0;
      sens_edge_dn <= 1'b0;
    end else begin
      if (wr_ok) mem[bus_idx] <= bus_wdata;
      sens_edge_up <= wr_d && bus_wdata[SCK_BIT] && !mem[D_OUT][SCK_BIT];
      sens_edge_dn <= wr_d && !bus_wdata[SCK_BIT] && mem[D_OUT][SCK_BIT];
    end
  end

  always_comb begin
    if (bus_idx == A_IN)
      bus_rdata = (mem[A_OUT] & mem[A_OE]) | (DW'(nand_rdy) << RDY_BIT);
    else if (bus_idx == D_IN)
      bus_rdata = (mem[D_OUT] & mem[D_OE]) | (DW'(sens_so) << SO_BIT);
    else if (bus_idx <= LAST)
      bus_rdata = mem[bus_idx];
    else
      bus_rdata = '0;
  end

  assign nand_ale = mem[A_OUT][ALE_BIT];
  assign nand_cle = mem[A_OUT][CLE_BIT];
  assign nand_ce  = mem[A_OUT][CE_BIT];
  assign sens_sck = mem[D_OUT][SCK_BIT];
  assign sens_si  = mem[D_OUT][SI_BIT];

  a_r5_strobes_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_idx == A_OUT) |=>
      (nand_ale == $past(bus_wdata[ALE_BIT]) && nand_cle == $past(bus_wdata[CLE_BIT])
       && nand_ce == $past(bus_wdata[CE_BIT])));

  a_r7_edge_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && bus_wdata[SCK_BIT] != sens_sck) |=>
      (sens_edge_up == sens_sck && sens_edge_dn == !sens_sck));

  a_r7_no_spurious_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_d && bus_wdata[SCK_BIT] != sens_sck) |=> !(sens_edge_up || sens_edge_dn));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sens_edge_up, sens_edge_dn}));

  a_r8_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !(&bus_be)) |=>
      ($stable(nand_ale) && $stable(nand_cle) && $stable(nand_ce) && $stable(sens_sck)
       && $stable(sens_si)));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idx > LAST) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_ports_bench.sv
module gpio_ports_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [4:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nand_rdy = 1'b0, sens_so = 1'b0;
  logic        nand_ale, nand_cle, nand_ce, sens_sck, sens_si, sens_edge_up, sens_edge_dn;

  int applied = 0, bad = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  gpio_ports u_gpio_ports (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_be(bus_be),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nand_rdy(nand_rdy), .sens_so(sens_so), .nand_ale(nand_ale), .nand_cle(nand_cle),
    .nand_ce(nand_ce), .sens_sck(sens_sck), .sens_si(sens_si),
    .sens_edge_up(sens_edge_up), .sens_edge_dn(sens_edge_dn)
  );

  // {we, idx, wdata, rdy, so, expected read}
  localparam int NV = 17;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 5'h00, 32'h0000_00F0, 1'b0, 1'b0, 32'h0},
    {1'b1, 5'h02, 32'h0000_0060, 1'b0, 1'b0, 32'h0},
    {1'b0, 5'h01, 32'h0,         1'b0, 1'b0, 32'h0000_0060},
    {1'b0, 5'h01, 32'h0,         1'b1, 1'b0, 32'h0000_00E0},
    {1'b0, 5'h00, 32'h0,         1'b1, 1'b0, 32'h0000_00F0},
    {1'b1, 5'h10, 32'h1234_5673, 1'b0, 1'b0, 32'h0},
    {1'b1, 5'h12, 32'h0000_FF0F, 1'b0, 1'b0, 32'h0},
    {1'b0, 5'h11, 32'h0,         1'b0, 1'b0, 32'h0000_5603},
    {1'b0, 5'h11, 32'h0,         1'b0, 1'b1, 32'h0000_5613},
    {1'b0, 5'h12, 32'h0,         1'b0, 1'b1, 32'h0000_FF0F},
    {1'b1, 5'h05, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0},
    {1'b0, 5'h05, 32'h0,         1'b0, 1'b0, 32'hDEAD_BEEF},
    {1'b0, 5'h16, 32'h0,         1'b0, 1'b0, 32'h0},
    {1'b1, 5'h16, 32'h0000_0001, 1'b0, 1'b0, 32'h0},
    {1'b0, 5'h16, 32'h0,         1'b0, 1'b0, 32'h0000_0001},
    {1'b1, 5'h19, 32'h0000_FFFF, 1'b0, 1'b0, 32'h0},
    {1'b0, 5'h19, 32'h0,         1'b0, 1'b0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_be = be; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] d);
    bus_idx = idx;
    #1ns;
    d = bus_rdata;
  endtask

  initial begin
    #400us;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, r); chk("R1 word0", r, 32'h0);
    rd(5'h10, r); chk("R1 word16", r, 32'h0);
    chk("R1 pins", {27'h0, nand_ale, nand_cle, nand_ce, sens_sck, sens_si}, 32'h0);

    // Table: R2/R3/R4/R9
    for (int i = 0; i < NV; i++) begin
      nand_rdy = VEC[i][33];
      sens_so  = VEC[i][32];
      if (VEC[i][71]) wr(VEC[i][70:66], VEC[i][65:34], 4'hF);
      else begin
        @(negedge clk);
        rd(VEC[i][70:66], r);
        chk($sformatf("R2/R3/R4/R9 vector %0d", i), r, VEC[i][31:0]);
      end
    end
    rd(5'h09, r); chk("R9 no alias into word 9", r, 32'h0);

    // R5 strobes: word 0 holds F0 -> ale=1 cle=1 ce=1
    chk("R5 strobes F0", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h7);
    wr(5'h00, 32'h0000_0020, 4'hF);
    chk("R5 strobes 20", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h2);

    // R6 word 16 holds ...73 -> sck=1 si=1
    chk("R6 sck si", {30'h0, sens_sck, sens_si}, 32'h3);

    // R7 edges
    wr(5'h10, 32'h0000_0001, 4'hF);
    chk("R7 falling pulse", {30'h0, sens_edge_up, sens_edge_dn}, 32'h1);
    chk("R6 after fall", {30'h0, sens_sck, sens_si}, 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {30'h0, sens_edge_up, sens_edge_dn}, 32'h0);
    wr(5'h10, 32'h0000_0000, 4'hF);
    chk("R7 unchanged clock no pulse", {30'h0, sens_edge_up, sens_edge_dn}, 32'h0);
    chk("R6 si low", {31'h0, sens_si}, 32'h0);
    wr(5'h10, 32'h0000_0002, 4'hF);
    chk("R7 rising pulse", {30'h0, sens_edge_up, sens_edge_dn}, 32'h2);

    // R8 partial writes ignored
    wr(5'h10, 32'h0000_0000, 4'h7);
    chk("R8 no pulse", {30'h0, sens_edge_up, sens_edge_dn}, 32'h0);
    rd(5'h10, r); chk("R8 word16 kept", r, 32'h0000_0002);
    wr(5'h00, 32'h0000_0070, 4'hE);
    chk("R8 strobes kept", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h2);

    // R1 reset clears again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(5'h05, r); chk("R1 word5 cleared", r, 32'h0);
    chk("R1 pins cleared", {27'h0, nand_ale, nand_cle, nand_ce, sens_sck, sens_si}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule